// File: doc/BRIEF.md
# Write-Through Cache Controller

This block is a direct-mapped cache controller that sits between a processor request port and a memory-side bus. Each processor access carries two attributes: a non-cacheable flag and a read-only flag for its region. Cacheable reads look up a 16-line, 4-word-per-line store. A hit is answered from the local array with no bus traffic. A miss fetches the whole 16-byte-aligned line as a 4-beat wrapping burst that starts with the requested word. The processor is released as soon as that first word arrives, while the rest of the line keeps filling.

Writes always go to the bus. A cacheable write that hits also merges its byte-strobed data into the cached word. A cacheable write that misses allocates nothing. Because every write goes to memory, lines never hold modified data. Non-cacheable reads and writes skip the lookup and go to the bus as single transfers. A cacheable write to a region flagged read-only ends with an error response. The block has no hardware coherency with other bus masters. Software keeps memory consistent by pulsing an invalidate input, which clears every line in a 16-cycle sweep. Processor requests wait until the sweep has finished.

Top module: `wt_cache_ctrl`

## Requirements
- R1: After reset, `cpu_done`, `cpu_err` and `mem_req` are low, and every line is invalid, so the first cacheable read of any address misses.
- R2: A cacheable read miss issues one request with `mem_burst`=1, `mem_we`=0 and `mem_addr` equal to the word-aligned request address. Memory returns 4 beats for word offsets c, c+1, c+2, c+3 (mod 4) of the 16-byte block, where c is the requested word. `cpu_done` rises, carrying the first beat as `cpu_rdata`, on the clock edge that takes that first beat.
- R3: After a fill completes, a cacheable read of any word of that line returns the cached word and issues no bus request.
- R4: A cacheable write that misses issues one single write (`mem_burst`=0) with the request's data and byte strobes, and leaves the cache unchanged: a later read of that line still misses.
- R5: A cacheable write that hits updates only the strobed bytes (`cpu_be` bit b covers data bits 8b+7..8b) of the cached word and also issues the same single write on the bus.
- R6: With `cpu_nc`=1, a read is one single bus read and a write is one single bus write. The cache is neither consulted nor updated: a non-cacheable read of a cached address returns memory contents, and a non-cacheable write to a cached address leaves the cached word as it was.
- R7: A cacheable write with `cpu_ro`=1 completes with `cpu_done` and `cpu_err` both high, issues no bus request and leaves the cache unchanged. `cpu_ro` has no effect on reads or on non-cacheable writes.
- R8: A one-cycle pulse on `inv_start` invalidates all lines in one pass of 16 cycles. No new request is accepted until the pass ends, and afterwards every cacheable read misses.
- R9: When the controller is idle, a cacheable read hit or a read-only fault raises `cpu_done` for exactly one cycle, on the second rising clock edge after `cpu_req` is first sampled high.
- R10: `mem_req` stays high with `mem_addr`, `mem_we` and the write data unchanged until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request held high with stable fields until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_nc | input | 1 | 1 = non-cacheable access |
| cpu_ro | input | 1 | 1 = target region is read-only |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_be | input | DATA_W/8 | Byte strobes for writes |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Fault response, valid with `cpu_done` |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| inv_start | input | 1 | Pulse to invalidate the whole cache |
| mem_req | output | 1 | Bus request, held until `mem_ack` |
| mem_we | output | 1 | Bus write when high |
| mem_burst | output | 1 | 1 = 4-beat wrapping line read |
| mem_addr | output | ADDR_W | Word-aligned bus address |
| mem_wdata | output | DATA_W | Bus write data |
| mem_be | output | DATA_W/8 | Bus byte strobes |
| mem_ack | input | 1 | Request accepted; completes a write |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | DATA_W | Read beat data |

## Verification
A hit or a fault is answered two edges after the request is first sampled. A miss is answered one edge after its first beat. A bus write completes on the edge that takes `mem_ack`. The bench drives inputs and samples outputs on falling edges. It measures latencies as counts of rising edges between the falling edge that drove the request and the falling edge that sees `cpu_done`. The memory model records the cycle of each first beat, so the timing of a miss is checked against that beat. Bus-transfer counts are compared one falling edge after completion, so that the model's own update of its counts has already taken place. Random acknowledge delays probe how long the bus request is held.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    WTC_IDLE,
    WTC_LOOKUP,
    WTC_BUS,
    WTC_FILL
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_valid,
  output logic [TAG_W-1:0] look_tag,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (clr_en) valid_q[clr_idx] <= 1'b0;
      if (set_en) valid_q[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[set_idx] <= set_tag;
  end

  assign look_valid = valid_q[look_idx];
  assign look_tag   = tag_q[look_idx];

  AST_SET_CLR_APART: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en && (set_idx == clr_idx))); // R8
endmodule

// File: rtl/wtc_data_ram.sv
module wtc_data_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BE_W; b++) begin
        if (be[b]) store[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
    rdata <= store[raddr];
  end
endmodule

// File: rtl/wtc_inv_sweep.sv
module wtc_inv_sweep #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick,
  input  logic             allow,
  output logic             hold,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  logic             pend_q;
  logic             busy_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) busy_q <= 1'b0;
      end else if (pend_q && allow) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end
      if (kick) pend_q <= 1'b1;
    end
  end

  assign hold    = pend_q | busy_q;
  assign clr_en  = busy_q;
  assign clr_idx = cnt_q;

  AST_SWEEP_RUNS_ON: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != LAST) |=> busy_q); // R8
  AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == LAST) |=> !busy_q); // R8
endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_nc,
  input  logic              cpu_ro,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [BE_W-1:0]   cpu_be,
  output logic              cpu_done,
  output logic              cpu_err,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              inv_start,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_burst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [BE_W-1:0]   mem_be,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  import wtc_pkg::*;

  localparam int BOFF_W  = $clog2(BE_W);
  localparam int WOFF_W  = $clog2(WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int IDX_LSB = BOFF_W + WOFF_W;
  localparam int TAG_LSB = IDX_LSB + IDX_W;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam int RAM_AW  = IDX_W + WOFF_W;
  localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(WORDS - 1);

  wtc_state_e state_q;

  logic              rq_we, rq_nc, rq_ro;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wdata;
  logic [BE_W-1:0]   rq_be;
  logic [WOFF_W-1:0] beat_q;

  logic [IDX_W-1:0]  rq_idx, cpu_idx;
  logic [WOFF_W-1:0] rq_word, cpu_word, fill_word;
  logic [TAG_W-1:0]  rq_tag;
  logic [ADDR_W-1:0] rq_waddr;

  assign rq_idx    = rq_addr[IDX_LSB +: IDX_W];
  assign rq_word   = rq_addr[BOFF_W +: WOFF_W];
  assign rq_tag    = rq_addr[TAG_LSB +: TAG_W];
  assign cpu_idx   = cpu_addr[IDX_LSB +: IDX_W];
  assign cpu_word  = cpu_addr[BOFF_W +: WOFF_W];
  assign fill_word = rq_word + beat_q;
  assign rq_waddr  = {rq_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};

  // Lookup and line bookkeeping
  logic             look_valid;
  logic [TAG_W-1:0] look_tag;
  logic             hit;
  logic             set_en, fsm_clr;
  logic             sweep_hold, sweep_clr;
  logic [IDX_W-1:0] sweep_idx;
  logic             clr_en;
  logic [IDX_W-1:0] clr_idx;

  assign hit = look_valid && (look_tag == rq_tag);

  wtc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .look_idx  (rq_idx),
    .look_valid(look_valid),
    .look_tag  (look_tag),
    .set_en    (set_en),
    .set_idx   (rq_idx),
    .set_tag   (rq_tag),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx)
  );

  wtc_inv_sweep #(.LINES(LINES)) u_sweep (
    .clk    (clk),
    .rst    (rst),
    .kick   (inv_start),
    .allow  (state_q == WTC_IDLE),
    .hold   (sweep_hold),
    .clr_en (sweep_clr),
    .clr_idx(sweep_idx)
  );

  assign fsm_clr = (state_q == WTC_LOOKUP) && !rq_nc && !rq_we && !hit;
  assign clr_en  = sweep_clr | fsm_clr;
  assign clr_idx = sweep_clr ? sweep_idx : rq_idx;
  assign set_en  = (state_q == WTC_FILL) && mem_rvalid && mem_burst && (beat_q == LAST_BEAT);

  // Data array
  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [BE_W-1:0]   ram_be;
  logic [DATA_W-1:0] ram_q;

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = {rq_idx, rq_word};
    ram_wdata = rq_wdata;
    ram_be    = rq_be;
    if (state_q == WTC_LOOKUP && rq_we && !rq_nc && !rq_ro && hit) begin
      ram_we = 1'b1;
    end
    if (state_q == WTC_FILL && mem_rvalid && mem_burst) begin
      ram_we    = 1'b1;
      ram_waddr = {rq_idx, fill_word};
      ram_wdata = mem_rdata;
      ram_be    = '1;
    end
  end

  wtc_data_ram #(.DEPTH(LINES * WORDS), .DATA_W(DATA_W)) u_data (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .be   (ram_be),
    .raddr({cpu_idx, cpu_word}),
    .rdata(ram_q)
  );

  // Control sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= WTC_IDLE;
      cpu_done  <= 1'b0;
      cpu_err   <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_burst <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
      rq_we     <= 1'b0;
      rq_nc     <= 1'b0;
      rq_ro     <= 1'b0;
      rq_addr   <= '0;
      rq_wdata  <= '0;
      rq_be     <= '0;
      beat_q    <= '0;
    end else begin
      cpu_done <= 1'b0;
      cpu_err  <= 1'b0;
      unique case (state_q)
        WTC_IDLE: begin
          if (cpu_req && !sweep_hold) begin
            rq_we    <= cpu_we;
            rq_nc    <= cpu_nc;
            rq_ro    <= cpu_ro;
            rq_addr  <= cpu_addr;
            rq_wdata <= cpu_wdata;
            rq_be    <= cpu_be;
            state_q  <= WTC_LOOKUP;
          end
        end
        WTC_LOOKUP: begin
          mem_addr  <= rq_waddr;
          mem_wdata <= rq_wdata;
          mem_we    <= rq_we;
          mem_be    <= rq_we ? rq_be : '1;
          if (rq_nc) begin
            mem_req   <= 1'b1;
            mem_burst <= 1'b0;
            state_q   <= WTC_BUS;
          end else if (rq_we && rq_ro) begin
            cpu_done <= 1'b1;
            cpu_err  <= 1'b1;
            state_q  <= WTC_IDLE;
          end else if (!rq_we && hit) begin
            cpu_done  <= 1'b1;
            cpu_rdata <= ram_q;
            state_q   <= WTC_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_burst <= !rq_we;
            state_q   <= WTC_BUS;
          end
        end
        WTC_BUS: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            beat_q  <= '0;
            if (mem_we) begin
              cpu_done <= 1'b1;
              state_q  <= WTC_IDLE;
            end else begin
              state_q <= WTC_FILL;
            end
          end
        end
        WTC_FILL: begin
          if (mem_rvalid) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == '0) begin
              cpu_done  <= 1'b1;
              cpu_rdata <= mem_rdata;
            end
            if (!mem_burst || beat_q == LAST_BEAT) state_q <= WTC_IDLE;
          end
        end
        default: state_q <= WTC_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done); // R9
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    cpu_err |-> (cpu_done && !mem_req)); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
  AST_BURST_IS_READ: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_burst) |-> !mem_we); // R2
  AST_NC_NO_ARRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !rq_nc); // R6
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    (state_q == WTC_LOOKUP && !rq_nc && !rq_we && hit) |=> !mem_req); // R3
  AST_SWEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    sweep_clr |-> (state_q == WTC_IDLE && !mem_req && !cpu_done)); // R8
endmodule

// File: tb/wt_cache_ctrl_test.sv
module wt_cache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 0, cpu_we = 0, cpu_nc = 0, cpu_ro = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [3:0]  cpu_be = 0;
  logic        cpu_done, cpu_err;
  logic [31:0] cpu_rdata;
  logic        inv_start = 0;
  logic        mem_req, mem_we, mem_burst;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  wt_cache_ctrl uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_nc(cpu_nc),
    .cpu_ro(cpu_ro), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_done(cpu_done), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
    .inv_start(inv_start), .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int n_single = 0, n_burst = 0, n_wr = 0, first_beat_cyc = 0;
  logic [31:0] mem [1024];
  logic [31:0] exp_mem [1024];
  bit          mv [16];
  logic [23:0] mtag [16];
  logic [31:0] mdat [16][4];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  // Memory model with random acknowledge delay
  initial begin
    logic [31:0] a, wd;
    logic        we, bu;
    logic [3:0]  be;
    forever begin
      @(negedge clk);
      if (mem_req && !rst) begin
        a = mem_addr; we = mem_we; bu = mem_burst; wd = mem_wdata; be = mem_be;
        chk(a[1:0] == 2'b00, "R2 word-aligned bus address", a, {a[31:2], 2'b00});
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk(mem_req && mem_addr == a && mem_we == we, "R10 request held until ack", mem_addr, a);
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        if (we) begin
          n_wr++;
          mem[a[11:2]] = merge(mem[a[11:2]], wd, be);
        end else begin
          if (bu) n_burst++; else n_single++;
          for (int b = 0; b < (bu ? 4 : 1); b++) begin
            logic [1:0] w;
            w = a[3:2] + 2'(b);
            mem_rvalid = 1'b1;
            mem_rdata  = mem[{a[11:4], w}];
            if (b == 0) first_beat_cyc = cyc;
            @(negedge clk);
          end
          mem_rvalid = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int last_lat = 0;

  task automatic access(input bit we, nc, ro, input logic [31:0] a, wd, input logic [3:0] be,
                        output logic [31:0] rd, output bit err, output int done_cyc);
    int t0;
    bit got = 0;
    cpu_req = 1; cpu_we = we; cpu_nc = nc; cpu_ro = ro; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    t0 = cyc;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (cpu_done) begin got = 1; break; end
    end
    chk(got, "R9 access completes", 0, 1);
    rd = cpu_rdata; err = cpu_err; done_cyc = cyc; last_lat = cyc - t0;
    cpu_req = 0;
  endtask

  task automatic do_op(input bit we, nc, ro, input logic [31:0] a, wd, input logic [3:0] be);
    logic [3:0]  idx = a[7:4];
    logic [1:0]  w = a[3:2];
    logic [9:0]  wi = a[11:2];
    bit          hit = !nc && mv[idx] && mtag[idx] == a[31:8];
    int s0 = n_single, b0 = n_burst, w0 = n_wr;
    int dc;
    logic [31:0] rd;
    bit err;
    access(we, nc, ro, a, wd, be, rd, err, dc);
    @(negedge clk);
    if (we && !nc && ro) begin
      chk(err == 1, "R7 read-only fault flagged", 32'(err), 1);
      chk(n_wr == w0 && n_single == s0 && n_burst == b0, "R7 no bus on fault", n_wr - w0, 0);
    end else if (we) begin
      chk(err == 0, nc ? "R6 nc write no error" : "R4 write no error", 32'(err), 0);
      chk(n_wr == w0 + 1 && n_burst == b0, hit ? "R5 write hit goes to bus" : (nc ? "R6 nc write single" : "R4 write miss single write"), n_wr - w0, 1);
      exp_mem[wi] = merge(exp_mem[wi], wd, be);
      if (hit) mdat[idx][w] = merge(mdat[idx][w], wd, be);
    end else if (nc) begin
      chk(n_single == s0 + 1 && n_burst == b0, "R6 nc read single", n_single - s0, 1);
      chk(rd == exp_mem[wi], "R6 nc read data from memory", rd, exp_mem[wi]);
    end else if (hit) begin
      chk(n_single == s0 && n_burst == b0, "R3 hit no bus", n_burst - b0, 0);
      chk(rd == mdat[idx][w], "R3 hit data", rd, mdat[idx][w]);
    end else begin
      chk(n_burst == b0 + 1, "R2 miss bursts", n_burst - b0, 1);
      chk(rd == exp_mem[wi], "R2 critical word data", rd, exp_mem[wi]);
      chk(dc == first_beat_cyc + 1, "R2 done with first beat", dc, first_beat_cyc + 1);
      mv[idx] = 1; mtag[idx] = a[31:8];
      for (int k = 0; k < 4; k++) mdat[idx][k] = exp_mem[{wi[9:2], 2'(k)}];
    end
    if (!(we && !nc && ro) && !we) chk(err == 0, "R7 no error on read", 32'(err), 0);
  endtask

  task automatic invalidate();
    inv_start = 1; @(negedge clk); inv_start = 0;
    for (int i = 0; i < 16; i++) mv[i] = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) begin
      mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
      exp_mem[i] = mem[i];
    end
    for (int i = 0; i < 16; i++) mv[i] = 0;
    repeat (5) @(negedge clk);
    chk(!cpu_done && !cpu_err && !mem_req, "R1 reset outputs low", {cpu_done, cpu_err, mem_req}, 0);
    rst = 0;
    repeat (2) @(negedge clk);

    // R1/R2: first read misses; critical word 3 wraps
    do_op(0, 0, 0, 32'h10C, 0, 0);
    repeat (4) @(negedge clk);
    // R3/R9: other word hits in two edges
    do_op(0, 0, 0, 32'h100, 0, 0);
    chk(last_lat == 2, "R9 hit latency", last_lat, 2);
    // R5: partial write hit then read back
    do_op(1, 0, 0, 32'h104, 32'hAABBCCDD, 4'b0101);
    do_op(0, 0, 0, 32'h104, 0, 0);
    // R4: write miss, no allocate
    do_op(1, 0, 0, 32'h230, 32'h11223344, 4'b1111);
    do_op(0, 0, 0, 32'h230, 0, 0);
    // R6: nc write to cached word leaves cache stale; nc read sees memory
    do_op(1, 1, 0, 32'h108, 32'hDEADBEEF, 4'b1111);
    do_op(0, 0, 0, 32'h108, 0, 0);
    do_op(0, 1, 0, 32'h108, 0, 0);
    // R7: fault on read-only cacheable write, cache untouched
    repeat (3) @(negedge clk);
    do_op(1, 0, 1, 32'h100, 32'h0BADF00D, 4'b1111);
    chk(last_lat == 2, "R9 fault latency", last_lat, 2);
    do_op(0, 0, 0, 32'h100, 0, 0);
    do_op(1, 1, 1, 32'h300, 32'h12345678, 4'b1111);
    // R8: invalidate holds the next request, then it misses
    invalidate();
    do_op(0, 0, 0, 32'h100, 0, 0);
    chk(last_lat > 18, "R8 request held during sweep", last_lat, 19);

    for (int n = 0; n < 600; n++) begin
      logic [31:0] a = {20'h0, 2'($urandom % 4), 2'b00, 4'($urandom), 2'($urandom), 2'b00};
      int r = $urandom % 100;
      if (n % 97 == 96) invalidate();
      do_op(r < 35, (r % 5) == 0, (r % 7) == 0, a, $urandom, 4'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule